// File: doc/BRIEF.md
# Battery presence detection sequencer

After a charge cycle terminates, this block decides whether a cell is still attached to the charger output. It opens a current-sink test window of fixed length, counted in ticks of an external timebase. If the battery voltage stays above the detect level on every tick of that window, the block reports a battery and requests a fresh charge cycle.

If the voltage sags even once, a current-source window follows. In that window the short-charge source is pulsed hysteretically between two voltage levels, which keeps a pack protector switch closed. When the source window ends, another sink window opens. The two windows alternate until a battery is found, charging is disabled, or the charger goes to high impedance.

The analog current sources and the threshold comparators sit outside the block. Its inputs are the comparator flags, a charge-enable, a high-impedance request and a tick. Its outputs are the two source/sink enables, a battery-present strobe and a restart-charge strobe.

Top module: `batt_detect_seq`

## Requirements
- R1: After reset, `sink_en`, `src_en`, `batt_present` and `restart_pulse` are all low and the block is idle.
- R2: `start` is acted upon only while the block is idle, `chg_en` is high and `hiz` is low. In that case `sink_en` is high from the next cycle on; otherwise `start` has no effect.
- R3: A sink window lasts exactly `SINK_TICKS` cycles in which `tick` is high; cycles without `tick` do not advance it. `sink_en` and `src_en` are never high together.
- R4: `batt_present` is high for one cycle, on the final tick of a sink window, only if `v_above_det` was high on every tick of that window. The block is idle on the following cycle.
- R5: `restart_pulse` is high for exactly the one cycle after each `batt_present` cycle and at no other time.
- R6: If `v_above_det` is low on any tick of a sink window, a source window of `SRC_TICKS` ticks follows the last tick of that sink window, and `src_en` is high on the first cycle of the source window.
- R7: Within a source window, `v_at_hi` high turns `src_en` off from the next cycle, and `v_below_lo` high turns it on from the next cycle. If both are high, `v_at_hi` wins.
- R8: The cycle after the last tick of a source window, a new sink window begins, with the record of sags cleared.
- R9: While `chg_en` is low or `hiz` is high, the block returns to idle on the next cycle, with both enables low and no `restart_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Charge termination reached; begin detection |
| chg_en | input | 1 | Charging enabled |
| hiz | input | 1 | High-impedance mode request |
| tick | input | 1 | Window timebase strobe |
| v_above_det | input | 1 | Battery voltage above detect level |
| v_at_hi | input | 1 | Battery voltage at or above upper source level |
| v_below_lo | input | 1 | Battery voltage at or below lower source level |
| sink_en | output | 1 | Enable detect current sink |
| src_en | output | 1 | Enable short-charge current source |
| batt_present | output | 1 | One-cycle strobe: battery found |
| restart_pulse | output | 1 | One-cycle strobe: begin a new charge cycle |

## Verification
The hardest case to reach is the second half of the hysteresis: `src_en` turning back on from the lower level. To see it, the source must first be switched off by the upper level, and the lower level must then be seen while the source window still has ticks left. The stimulus gets there by forcing a sag in the first sink window to reach the source window. It then applies the upper flag early in that window, applies the lower flag two ticks later, and observes the source come back on in the window's final cycle. In the same sink window that follows, a sag applied on a cycle with no tick shows that only ticked samples count toward the decision.

// File: rtl/batt_detect_seq.sv
module batt_detect_seq #(
  parameter int SINK_TICKS = 4000,
  parameter int SRC_TICKS  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic chg_en,
  input  logic hiz,
  input  logic tick,
  input  logic v_above_det,
  input  logic v_at_hi,
  input  logic v_below_lo,
  output logic sink_en,
  output logic src_en,
  output logic batt_present,
  output logic restart_pulse
);
  localparam int MAXT = (SINK_TICKS > SRC_TICKS) ? SINK_TICKS : SRC_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SINK, S_SRC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          dip;
  logic          src_on;

  wire quit      = !chg_en || hiz;
  wire sink_last = tick && (cnt == CW'(SINK_TICKS - 1));
  wire src_last  = tick && (cnt == CW'(SRC_TICKS - 1));
  wire clean     = !dip && v_above_det;

  assign sink_en      = (st == S_SINK);
  assign src_en       = (st == S_SRC) && src_on;
  assign batt_present = (st == S_SINK) && !quit && sink_last && clean;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cnt           <= '0;
      dip           <= 1'b0;
      src_on        <= 1'b0;
      restart_pulse <= 1'b0;
    end else begin
      restart_pulse <= batt_present;
      case (st)
        S_IDLE: begin
          src_on <= 1'b0;
          if (start && !quit) begin
            st  <= S_SINK;
            cnt <= '0;
            dip <= 1'b0;
          end
        end
        S_SINK: begin
          if (quit) begin
            st <= S_IDLE;
          end else if (tick) begin
            if (sink_last) begin
              cnt <= '0;
              if (clean) begin
                st <= S_IDLE;
              end else begin
                st     <= S_SRC;
                src_on <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
              if (!v_above_det) dip <= 1'b1;
            end
          end
        end
        S_SRC: begin
          if (quit) begin
            st     <= S_IDLE;
            src_on <= 1'b0;
          end else begin
            if (v_at_hi)         src_on <= 1'b0;
            else if (v_below_lo) src_on <= 1'b1;
            if (src_last) begin
              st  <= S_SINK;
              cnt <= '0;
              dip <= 1'b0;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/batt_detect_seq_chk.sv
module batt_detect_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic chg_en,
  input logic hiz,
  input logic tick,
  input logic v_above_det,
  input logic v_at_hi,
  input logic v_below_lo,
  input logic sink_en,
  input logic src_en,
  input logic batt_present,
  input logic restart_pulse
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sink_en && src_en));

  p_present_in_sink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    batt_present |-> (sink_en && v_above_det && tick));

  p_present_then_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    batt_present |=> (!sink_en && !src_en));

  p_restart_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    batt_present |=> restart_pulse);

  p_restart_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> $past(batt_present));

  p_src_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en && v_at_hi) |=> !src_en);

  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_en || hiz) |=> (!sink_en && !src_en && !restart_pulse));
endmodule

bind batt_detect_seq batt_detect_seq_chk u_chk (.*);

// File: tb/batt_detect_seq_test.sv
module batt_detect_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, chg_en = 1'b1, hiz = 1'b0, tick = 1'b0;
  logic v_above_det = 1'b1, v_at_hi = 1'b0, v_below_lo = 1'b0;
  logic sink_en, src_en, batt_present, restart_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] e;
    string      req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  batt_detect_seq #(.SINK_TICKS(4), .SRC_TICKS(5)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chg_en(chg_en), .hiz(hiz),
    .tick(tick), .v_above_det(v_above_det), .v_at_hi(v_at_hi),
    .v_below_lo(v_below_lo), .sink_en(sink_en), .src_en(src_en),
    .batt_present(batt_present), .restart_pulse(restart_pulse)
  );

  // expected {sink_en, src_en, batt_present, restart_pulse}
  task automatic d(input logic s, ce, hz, tk, ab, hi, lo,
                   input logic [3:0] e, input string req);
    start = s; chg_en = ce; hiz = hz; tick = tk;
    v_above_det = ab; v_at_hi = hi; v_below_lo = lo;
    q.push_back('{e, req});
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      logic [3:0] got;
      it  = q.pop_front();
      got = {sink_en, src_en, batt_present, restart_pulse};
      checks++;
      if (got !== it.e) begin
        errors++;
        $display("FAIL %s got %b expected %b", it.req, got, it.e);
      end
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    d(0,1,0,0,1,0,0, 4'b0000, "R1 reset idle");
    // present battery
    d(1,1,0,1,1,0,0, 4'b0000, "R2 start");
    d(0,1,0,1,1,0,0, 4'b1000, "R2 sink on");
    d(0,1,0,1,1,0,0, 4'b1000, "R3 sink tick2");
    d(0,1,0,1,1,0,0, 4'b1000, "R3 sink tick3");
    d(0,1,0,1,1,0,0, 4'b1010, "R4 present last tick");
    d(0,1,0,1,1,0,0, 4'b0001, "R5 restart");
    d(0,1,0,1,1,0,0, 4'b0000, "R5 restart single");
    // absent battery, alternation and hysteresis
    d(1,1,0,1,1,0,0, 4'b0000, "R2 start");
    d(0,1,0,1,0,0,0, 4'b1000, "R6 sag");
    d(0,1,0,1,1,0,0, 4'b1000, "R3 sink");
    d(0,1,0,1,1,0,0, 4'b1000, "R3 sink");
    d(0,1,0,1,1,0,0, 4'b1000, "R6 no present after sag");
    d(0,1,0,1,1,0,0, 4'b0100, "R6 source on");
    d(0,1,0,1,1,1,0, 4'b0100, "R7 upper seen");
    d(0,1,0,1,1,0,0, 4'b0000, "R7 source off");
    d(0,1,0,1,1,0,1, 4'b0000, "R7 lower seen");
    d(0,1,0,1,1,0,0, 4'b0100, "R7 source back on");
    d(0,1,0,0,0,0,0, 4'b1000, "R8 new sink window");
    d(0,1,0,1,1,0,0, 4'b1000, "R3 untick ignored");
    d(0,1,0,1,1,0,0, 4'b1000, "R3 sink");
    d(0,1,0,1,1,0,0, 4'b1000, "R3 sink");
    d(0,1,0,1,1,0,0, 4'b1010, "R8 present in later window");
    d(0,1,0,1,1,0,0, 4'b0001, "R5 restart");
    // start gating and exit from sink
    d(1,1,1,1,1,0,0, 4'b0000, "R2 start with hiz");
    d(1,0,0,1,1,0,0, 4'b0000, "R2 start with chg_en low");
    d(1,1,0,1,1,0,0, 4'b0000, "R2 start ignored result");
    d(0,1,0,1,1,0,0, 4'b1000, "R2 sink on");
    d(0,1,1,1,1,0,0, 4'b1000, "R9 hiz in sink");
    d(0,1,0,1,1,0,0, 4'b0000, "R9 idle no restart");
    d(0,1,0,1,1,0,0, 4'b0000, "R9 stays idle");
    // exit from source, both levels
    d(1,1,0,1,1,0,0, 4'b0000, "R2 start");
    d(0,1,0,1,0,0,0, 4'b1000, "R6 sag");
    d(0,1,0,1,0,0,0, 4'b1000, "R6 sag");
    d(0,1,0,1,0,0,0, 4'b1000, "R6 sag");
    d(0,1,0,1,0,0,0, 4'b1000, "R6 sag last");
    d(0,1,0,1,0,1,1, 4'b0100, "R7 both levels");
    d(0,0,0,1,0,0,0, 4'b0000, "R7 upper wins");
    d(0,1,0,1,0,0,0, 4'b0000, "R9 idle after chg_en low");
    d(0,1,0,1,0,0,0, 4'b0000, "R9 stays idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule